// File: doc/BRIEF.md
# PHY Link-Status Poller with Change Interrupt

This block walks a contiguous, programmable window of PHY addresses and reads two management registers from each PHY: the basic status register and then the basic control register. From these two results it builds a compact per-port status word that holds link, duplex and speed. It keeps one such word for every port. When a poll returns a link state that differs from the stored one, it raises a per-port change flag. The unmasked change flags are combined into one interrupt line.

Software programs a control register with an enable bit, a preamble option, a 6-bit management clock setting and the first and last PHY addresses of the window. It clears change flags by writing ones, and it can silence individual ports with a mask register. The management bus itself is outside the block. The poller issues read requests on a simple valid/ready request port and takes each 16-bit result on a response strobe.

Top module: `phy_link_poller`

## Requirements
- R1: After reset, every register reads as zero, `irq` is low and no read request is issued.
- R2: The control register sits at register address 0. Bit 31 enables polling. Bit 30 drives `mdio_preamble`. Bits 29:24 drive `mdio_clk_cfg`. Bits 12:8 hold the last address and bits 4:0 the first address. All other bits read back as zero.
- R3: Each sweep visits the PHY addresses from the first through the lower of the last address and NUM_PORTS-1, in ascending order. For each address it issues a read of MII register 1 and then a read of MII register 0. Sweeps repeat while polling is enabled. No request carries an address of NUM_PORTS or above.
- R4: If the first address is greater than the clipped last address, no request is issued.
- R5: A register-0 request keeps `mdio_req_valid` high with the same address until `mdio_req_ready` accepts it.
- R6: The status word of port p reads at register address 8+p. Bit 0 is the link bit, taken from bit 2 of the register-1 result. Bit 1 is full duplex, taken from bit 8 of the register-0 result. Bits 3:2 are the speed. The speed is 10 when bit 6 of the register-0 result is set, and otherwise {0, bit 13}. So 00 means 10 Mb/s, 01 means 100 Mb/s and 10 means 1000 Mb/s.
- R7: A poll whose link bit differs from the stored link bit sets that port's change flag. The flags occupy bits 6:0 at register address 1. The new word is stored on the same clock edge.
- R8: Writing a one to a flag bit at address 1 clears it. Writing a zero leaves it unchanged.
- R9: If a change is detected on the same clock edge as a clearing write to that bit, the flag stays set.
- R10: The mask occupies bits 6:0 at register address 2. A set bit keeps that port's flag off `irq`, and `irq` is the OR of the unmasked flags. The mask never alters the flags.
- R11: When polling is disabled after a port's register-1 request has been accepted, that port's register-0 read still completes and updates its word. After that the sequencer idles and issues nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdio_req_valid | output | 1 | Read request valid |
| mdio_req_ready | input | 1 | Read request accepted |
| mdio_req_phy | output | 5 | PHY address of the request |
| mdio_req_reg | output | 5 | MII register number of the request |
| mdio_preamble | output | 1 | Preamble option for management frames |
| mdio_clk_cfg | output | 6 | Management clock setting |
| mdio_rsp_valid | input | 1 | Read result strobe |
| mdio_rsp_data | input | 16 | Read result |
| irq | output | 1 | Link-change interrupt |

## Verification
Several rules are checked on every cycle. A stalled register-0 request holds steady. No request addresses a port beyond the table. A detected change always survives into the flags, even when a clear arrives on the same edge. A clearing write empties the written bits when no change coincides. A full mask forces `irq` low. `irq` only rises after a poll update or a mask write. Other behaviour needs a scenario: the exact order of addresses over a sweep, the decoding of the speed and duplex fields, the empty window, and the completion of a read pair after polling is switched off. The bench covers these by comparing its log of requests and its register reads with values it computes from the PHY data it served.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  localparam int REG_W   = 32;
  localparam int RA_W    = 4;
  localparam int PHY_AW  = 5;
  localparam int MII_DW  = 16;

  // control register field positions
  localparam int CTL_EN_BIT     = 31;
  localparam int CTL_PRE_BIT    = 30;
  localparam int CTL_MDC_LSB    = 24;
  localparam int CTL_MDC_W      = 6;
  localparam int CTL_LAST_LSB   = 8;
  localparam int CTL_FIRST_LSB  = 0;

  // register map
  localparam logic [RA_W-1:0] RA_CTRL      = 4'd0;
  localparam logic [RA_W-1:0] RA_FLAGS     = 4'd1;
  localparam logic [RA_W-1:0] RA_MASK      = 4'd2;
  localparam logic [RA_W-1:0] RA_PORT_BASE = 4'd8;

  // management registers read per PHY
  localparam logic [PHY_AW-1:0] MII_STAT_REG = 5'd1;
  localparam logic [PHY_AW-1:0] MII_CTRL_REG = 5'd0;

  // bit positions inside the management results
  localparam int STAT_LINK_BIT   = 2;
  localparam int CTL_DUPLEX_BIT  = 8;
  localparam int CTL_SPD_LO_BIT  = 13;
  localparam int CTL_SPD_HI_BIT  = 6;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_STAT_REQ,
    SQ_STAT_WAIT,
    SQ_CTRL_REQ,
    SQ_CTRL_WAIT
  } seq_state_e;

  typedef struct packed {
    logic [1:0] speed;
    logic       duplex;
    logic       link;
  } port_word_t;

endpackage

// File: rtl/lsp_scan_seq.sv
module lsp_scan_seq
  import lsp_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int PIW       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_en,
  input  logic [PHY_AW-1:0] win_first,
  input  logic [PHY_AW-1:0] win_last,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [PHY_AW-1:0] req_phy,
  output logic [PHY_AW-1:0] req_reg,
  input  logic              rsp_valid,
  input  logic [MII_DW-1:0] rsp_data,
  output logic              upd_valid,
  output logic [PIW-1:0]    upd_port,
  output port_word_t        upd_word
);

  localparam logic [PHY_AW-1:0] TOP_ADDR = PHY_AW'(NUM_PORTS - 1);

  seq_state_e        state_q, state_d;
  logic [PHY_AW-1:0] cur_q, cur_d;
  logic [PHY_AW-1:0] stop_q, stop_d;
  logic              link_q;
  logic              cur_en, link_cap;
  logic [PHY_AW-1:0] last_eff;

  // result bits that carry no status for this block
  logic unused_rsp_bits;
  assign unused_rsp_bits = ^{rsp_data[15:14], rsp_data[12:9], rsp_data[7],
                             rsp_data[5:3], rsp_data[1:0]};

  assign last_eff = (win_last > TOP_ADDR) ? TOP_ADDR : win_last;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    stop_d    = stop_q;
    cur_en    = 1'b0;
    link_cap  = 1'b0;
    upd_valid = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (poll_en && (win_first <= last_eff)) begin
          cur_d   = win_first;
          stop_d  = last_eff;
          cur_en  = 1'b1;
          state_d = SQ_STAT_REQ;
        end
      end
      SQ_STAT_REQ: begin
        if (!poll_en)       state_d = SQ_IDLE;
        else if (req_ready) state_d = SQ_STAT_WAIT;
      end
      SQ_STAT_WAIT: begin
        if (rsp_valid) begin
          link_cap = 1'b1;
          state_d  = SQ_CTRL_REQ;
        end
      end
      SQ_CTRL_REQ: begin
        if (req_ready) state_d = SQ_CTRL_WAIT;
      end
      SQ_CTRL_WAIT: begin
        if (rsp_valid) begin
          upd_valid = 1'b1;
          if (!poll_en || (cur_q == stop_q)) begin
            state_d = SQ_IDLE;
          end else begin
            cur_d   = cur_q + PHY_AW'(1);
            cur_en  = 1'b1;
            state_d = SQ_STAT_REQ;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cur_q   <= '0;
      stop_q  <= '0;
      link_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cur_en)   cur_q  <= cur_d;
      if (cur_en)   stop_q <= stop_d;
      if (link_cap) link_q <= rsp_data[STAT_LINK_BIT];
    end
  end

  assign req_valid = ((state_q == SQ_STAT_REQ) && poll_en) || (state_q == SQ_CTRL_REQ);
  assign req_phy   = cur_q;
  assign req_reg   = (state_q == SQ_CTRL_REQ) ? MII_CTRL_REG : MII_STAT_REG;

  assign upd_port        = cur_q[PIW-1:0];
  assign upd_word.link   = link_q;
  assign upd_word.duplex = rsp_data[CTL_DUPLEX_BIT];
  assign upd_word.speed  = rsp_data[CTL_SPD_HI_BIT] ? 2'b10 : {1'b0, rsp_data[CTL_SPD_LO_BIT]};

endmodule

// File: rtl/lsp_port_table.sv
module lsp_port_table
  import lsp_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int PIW       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd_valid,
  input  logic [PIW-1:0]               upd_port,
  input  port_word_t                   upd_word,
  output port_word_t [NUM_PORTS-1:0]   words_o,
  output logic [NUM_PORTS-1:0]         chg_o
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_word_t word_q;
    logic       hit;

    assign hit      = upd_valid && (upd_port == PIW'(p));
    assign chg_o[p] = hit && (upd_word.link != word_q.link);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= upd_word;
    end

    assign words_o[p] = word_q;
  end

endmodule

// File: rtl/lsp_irq_ctrl.sv
module lsp_irq_ctrl #(
  parameter int NUM_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] chg,
  input  logic                 clr_we,
  input  logic [NUM_PORTS-1:0] clr_bits,
  input  logic                 mask_we,
  input  logic [NUM_PORTS-1:0] mask_bits,
  output logic [NUM_PORTS-1:0] flags_o,
  output logic [NUM_PORTS-1:0] mask_o,
  output logic                 irq_o
);

  logic [NUM_PORTS-1:0] flags_q, flags_d;
  logic [NUM_PORTS-1:0] mask_q;
  logic [NUM_PORTS-1:0] clr_eff;
  logic                 flags_en;

  // a change on the same edge overrides a clear
  always_comb begin
    clr_eff  = clr_we ? clr_bits : '0;
    flags_d  = (flags_q & ~clr_eff) | chg;
    flags_en = clr_we || (|chg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      if (flags_en) flags_q <= flags_d;
      if (mask_we)  mask_q  <= mask_bits;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & ~mask_q);

endmodule

// File: rtl/phy_link_poller.sv
module phy_link_poller
  import lsp_pkg::*;
#(
  parameter int NUM_PORTS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mdio_req_valid,
  input  logic              mdio_req_ready,
  output logic [PHY_AW-1:0] mdio_req_phy,
  output logic [PHY_AW-1:0] mdio_req_reg,
  output logic              mdio_preamble,
  output logic [5:0]        mdio_clk_cfg,
  input  logic              mdio_rsp_valid,
  input  logic [MII_DW-1:0] mdio_rsp_data,
  output logic              irq
);

  localparam int PIW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  // control register
  logic                 en_q, pre_q;
  logic [CTL_MDC_W-1:0] mdc_q;
  logic [PHY_AW-1:0]    first_q, last_q;
  logic                 ctrl_we;

  logic                 upd_valid;
  logic [PIW-1:0]       upd_port;
  port_word_t           upd_word;
  port_word_t [NUM_PORTS-1:0] port_words;
  logic [NUM_PORTS-1:0] port_chg;
  logic [NUM_PORTS-1:0] irq_flags, irq_mask;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[23:13], reg_wdata[7:5]};

  assign ctrl_we = reg_wr && (reg_addr == RA_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pre_q   <= 1'b0;
      mdc_q   <= '0;
      last_q  <= '0;
      first_q <= '0;
    end else if (ctrl_we) begin
      en_q    <= reg_wdata[CTL_EN_BIT];
      pre_q   <= reg_wdata[CTL_PRE_BIT];
      mdc_q   <= reg_wdata[CTL_MDC_LSB +: CTL_MDC_W];
      last_q  <= reg_wdata[CTL_LAST_LSB +: PHY_AW];
      first_q <= reg_wdata[CTL_FIRST_LSB +: PHY_AW];
    end
  end

  assign mdio_preamble = pre_q;
  assign mdio_clk_cfg  = mdc_q;

  lsp_scan_seq #(
    .NUM_PORTS (NUM_PORTS),
    .PIW       (PIW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll_en   (en_q),
    .win_first (first_q),
    .win_last  (last_q),
    .req_valid (mdio_req_valid),
    .req_ready (mdio_req_ready),
    .req_phy   (mdio_req_phy),
    .req_reg   (mdio_req_reg),
    .rsp_valid (mdio_rsp_valid),
    .rsp_data  (mdio_rsp_data),
    .upd_valid (upd_valid),
    .upd_port  (upd_port),
    .upd_word  (upd_word)
  );

  lsp_port_table #(
    .NUM_PORTS (NUM_PORTS),
    .PIW       (PIW)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_port  (upd_port),
    .upd_word  (upd_word),
    .words_o   (port_words),
    .chg_o     (port_chg)
  );

  lsp_irq_ctrl #(
    .NUM_PORTS (NUM_PORTS)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .chg       (port_chg),
    .clr_we    (reg_wr && (reg_addr == RA_FLAGS)),
    .clr_bits  (reg_wdata[NUM_PORTS-1:0]),
    .mask_we   (reg_wr && (reg_addr == RA_MASK)),
    .mask_bits (reg_wdata[NUM_PORTS-1:0]),
    .flags_o   (irq_flags),
    .mask_o    (irq_mask),
    .irq_o     (irq)
  );

  // register read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_CTRL) begin
      reg_rdata[CTL_EN_BIT]                    = en_q;
      reg_rdata[CTL_PRE_BIT]                   = pre_q;
      reg_rdata[CTL_MDC_LSB +: CTL_MDC_W]      = mdc_q;
      reg_rdata[CTL_LAST_LSB +: PHY_AW]        = last_q;
      reg_rdata[CTL_FIRST_LSB +: PHY_AW]       = first_q;
    end else if (reg_addr == RA_FLAGS) begin
      reg_rdata[NUM_PORTS-1:0] = irq_flags;
    end else if (reg_addr == RA_MASK) begin
      reg_rdata[NUM_PORTS-1:0] = irq_mask;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (reg_addr == (RA_PORT_BASE + RA_W'(p))) reg_rdata[3:0] = port_words[p];
      end
    end
  end

endmodule

// File: rtl/phy_link_poller_chk.sv
module phy_link_poller_chk
  import lsp_pkg::*;
#(
  parameter int NUM_PORTS = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [RA_W-1:0]      reg_addr,
  input logic [NUM_PORTS-1:0] wbits,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [PHY_AW-1:0]    req_phy,
  input logic [PHY_AW-1:0]    req_reg,
  input logic                 irq,
  input logic                 upd_valid,
  input logic [NUM_PORTS-1:0] chg,
  input logic [NUM_PORTS-1:0] flags
);

  // R5: a stalled register-0 request holds
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && (req_reg == MII_CTRL_REG))
      |=> (req_valid && $stable(req_phy) && (req_reg == MII_CTRL_REG)));

  // R3: never address beyond the port table
  assert_phy_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_phy < PHY_AW'(NUM_PORTS)));

  // R9: a detected change always lands in the flags
  assert_change_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |=> ((flags & $past(chg)) == $past(chg)));

  // R8: a clear without a coinciding change empties the written bits
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_FLAGS) && !(|chg)) |=> ((flags & $past(wbits)) == '0));

  // R10: full mask silences the interrupt
  assert_mask_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_MASK) && (&wbits)) |=> !irq);

  // R7: interrupt rises only after a poll update or a mask change
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(upd_valid || (reg_wr && (reg_addr == RA_MASK))));

endmodule

bind phy_link_poller phy_link_poller_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wbits     (reg_wdata[NUM_PORTS-1:0]),
  .req_valid (mdio_req_valid),
  .req_ready (mdio_req_ready),
  .req_phy   (mdio_req_phy),
  .req_reg   (mdio_req_reg),
  .irq       (irq),
  .upd_valid (upd_valid),
  .chg       (port_chg),
  .flags     (irq_flags)
);

// File: tb/sim_phy_link_poller.sv
`timescale 1ns/100ps
module sim_phy_link_poller;
  import lsp_pkg::*;

  localparam int NP   = 7;
  localparam int LOGN = 512;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdio_req_valid, mdio_req_ready;
  logic [4:0]  mdio_req_phy, mdio_req_reg;
  logic        mdio_preamble;
  logic [5:0]  mdio_clk_cfg;
  logic        mdio_rsp_valid;
  logic [15:0] mdio_rsp_data;
  logic        irq;

  phy_link_poller #(.NUM_PORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdio_req_valid(mdio_req_valid), .mdio_req_ready(mdio_req_ready),
    .mdio_req_phy(mdio_req_phy), .mdio_req_reg(mdio_req_reg),
    .mdio_preamble(mdio_preamble), .mdio_clk_cfg(mdio_clk_cfg),
    .mdio_rsp_valid(mdio_rsp_valid), .mdio_rsp_data(mdio_rsp_data), .irq(irq)
  );

  // PHY model state
  logic        phy_lnk [32];
  logic [15:0] phy_ctl [32];
  int          log_phy [LOGN];
  int          log_reg [LOGN];
  int          log_n;
  int          rsp_cur_reg;

  // expected state
  logic [3:0]  exp_word [NP];
  logic [6:0]  exp_flags, exp_mask;

  int n_chk, n_fail;
  bit done;

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] word_of(input logic lnk, input logic [15:0] c);
    return {(c[6] ? 2'b10 : {1'b0, c[13]}), c[8], lnk};
  endfunction

  // responder for the management read port
  initial begin
    bit acc, pend;
    int dly, a_phy, a_reg, p_phy, p_reg;
    acc = 0; pend = 0; dly = 0; a_phy = 0; a_reg = 0; p_phy = 0; p_reg = 0;
    mdio_req_ready = 1'b0; mdio_rsp_valid = 1'b0; mdio_rsp_data = '0;
    forever begin
      @(negedge clk);
      mdio_rsp_valid = 1'b0;
      if (!rst_n) begin
        acc = 0; pend = 0; mdio_req_ready = 1'b0;
      end else begin
        if (acc) begin
          if (log_n < LOGN) begin
            log_phy[log_n] = a_phy;
            log_reg[log_n] = a_reg;
          end
          log_n++;
          pend = 1; dly = $urandom % 3; p_phy = a_phy; p_reg = a_reg;
        end
        if (pend) begin
          if (dly == 0) begin
            mdio_rsp_valid = 1'b1;
            mdio_rsp_data  = (p_reg == 1) ? {13'b0, phy_lnk[p_phy], 2'b00} : phy_ctl[p_phy];
            rsp_cur_reg    = p_reg;
            pend = 0;
          end else dly--;
        end
        mdio_req_ready = pend ? 1'b0 : (($urandom % 4) != 0);
        acc   = mdio_req_ready && mdio_req_valid;
        a_phy = int'(mdio_req_phy);
        a_reg = int'(mdio_req_reg);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic check_log(input int f, input int le);
    int n, lim, mism;
    n = le - f + 1; mism = 0;
    lim = (log_n < LOGN) ? log_n : LOGN;
    for (int i = 0; i < lim; i++)
      if (log_phy[i] != f + (i / 2) % n || log_reg[i] != (((i % 2) == 0) ? 1 : 0)) mism++;
    chk(mism == 0 && log_n > 0, "R3 sweep order", mism, 0);
    chk((log_n % 2) == 0, "R11 pairs complete", log_n, 0);
  endtask

  task automatic check_state();
    logic [31:0] d;
    for (int p = 0; p < NP; p++) begin
      rd(RA_PORT_BASE + 4'(p), d);
      chk(d == {28'b0, exp_word[p]}, "R6 port word", d, {28'b0, exp_word[p]});
    end
    rd(RA_FLAGS, d);
    chk(d == {25'b0, exp_flags}, "R7 change flags", d, {25'b0, exp_flags});
    chk(irq == |(exp_flags & ~exp_mask), "R10 irq", irq, |(exp_flags & ~exp_mask));
  endtask

  task automatic run_window(input int f, input int l, input int cyc);
    int le;
    logic [3:0] w;
    logic [6:0] clr, msk;
    logic [5:0] mdc;
    logic pre;
    logic [31:0] d;
    le = (l > NP - 1) ? NP - 1 : l;
    for (int p = 0; p < 32; p++) begin
      phy_lnk[p] = 1'($urandom);
      phy_ctl[p] = 16'($urandom);
    end
    for (int p = f; p <= le; p++) begin
      w = word_of(phy_lnk[p], phy_ctl[p]);
      if (w[0] != exp_word[p][0]) exp_flags[p] = 1'b1;
      exp_word[p] = w;
    end
    msk = 7'($urandom); exp_mask = msk;
    wr(RA_MASK, {25'b0, msk});
    pre = 1'($urandom); mdc = 6'($urandom);
    log_n = 0;
    wr(RA_CTRL, {1'b1, pre, mdc, 11'b0, 5'(l), 3'b0, 5'(f)});
    chk(mdio_preamble == pre && mdio_clk_cfg == mdc, "R2 outputs", {mdio_preamble, mdio_clk_cfg}, {pre, mdc});
    repeat (cyc) @(negedge clk);
    wr(RA_CTRL, 32'h0);
    repeat (40) @(negedge clk);
    check_log(f, le);
    check_state();
    wr(RA_FLAGS, 32'h0);
    rd(RA_FLAGS, d);
    chk(d == {25'b0, exp_flags}, "R8 zero write", d, {25'b0, exp_flags});
    clr = 7'($urandom);
    wr(RA_FLAGS, {25'b0, clr});
    exp_flags = exp_flags & ~clr;
    rd(RA_FLAGS, d);
    chk(d == {25'b0, exp_flags}, "R8 clear", d, {25'b0, exp_flags});
    chk(irq == |(exp_flags & ~exp_mask), "R10 irq after clear", irq, |(exp_flags & ~exp_mask));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int t;
    void'($urandom(32'd24680));
    n_chk = 0; n_fail = 0; done = 0; log_n = 0; rsp_cur_reg = 0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    exp_flags = '0; exp_mask = '0;
    for (int p = 0; p < NP; p++) exp_word[p] = '0;
    for (int p = 0; p < 32; p++) begin phy_lnk[p] = 1'b0; phy_ctl[p] = '0; end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(RA_CTRL, d);  chk(d == 0, "R1 ctrl", d, 0);
    rd(RA_FLAGS, d); chk(d == 0, "R1 flags", d, 0);
    rd(RA_MASK, d);  chk(d == 0, "R1 mask", d, 0);
    check_state();
    chk(!irq && !mdio_req_valid, "R1 outputs", {irq, mdio_req_valid}, 0);

    // R2 readback; first address 31 lies outside the table so nothing polls (R4)
    log_n = 0;
    wr(RA_CTRL, 32'hFFFF_FFFF);
    rd(RA_CTRL, d);
    chk(d == 32'hFF00_1F1F, "R2 readback", d, 32'hFF00_1F1F);
    chk(mdio_preamble && mdio_clk_cfg == 6'h3F, "R2 outputs", {mdio_preamble, mdio_clk_cfg}, 7'h7F);
    repeat (40) @(negedge clk);
    chk(log_n == 0, "R4 first beyond table", log_n, 0);

    // R4 first > last
    wr(RA_CTRL, {1'b1, 1'b0, 6'd0, 11'b0, 5'd2, 3'b0, 5'd5});
    repeat (60) @(negedge clk);
    chk(log_n == 0 && !mdio_req_valid, "R4 empty window", log_n, 0);
    wr(RA_CTRL, 32'h0);

    // R6 speed code 11 stored as 10, single port window
    for (int p = 0; p < 32; p++) begin phy_lnk[p] = 1'b1; phy_ctl[p] = 16'h2140; end
    log_n = 0;
    wr(RA_CTRL, {1'b1, 1'b0, 6'd5, 11'b0, 5'd4, 3'b0, 5'd4});
    repeat (60) @(negedge clk);
    wr(RA_CTRL, 32'h0);
    repeat (30) @(negedge clk);
    exp_word[4] = 4'b1011; exp_flags[4] = 1'b1;
    check_log(4, 4);
    rd(RA_PORT_BASE + 4'd4, d);
    chk(d == 32'hB, "R6 speed 11 to 10", d, 32'hB);

    // R9 change on the same edge as a clear
    wr(RA_FLAGS, 32'h7F); exp_flags = '0;
    phy_lnk[3] = ~exp_word[3][0];
    phy_ctl[3] = 16'h0100;
    log_n = 0;
    wr(RA_CTRL, {1'b1, 1'b0, 6'd0, 11'b0, 5'd3, 3'b0, 5'd3});
    t = 0;
    do begin @(negedge clk); #2; t++; end while (!(mdio_rsp_valid && rsp_cur_reg == 0) && t < 200);
    reg_wr = 1'b1; reg_addr = RA_FLAGS; reg_wdata = 32'h8;
    @(negedge clk); #1; reg_wr = 1'b0;
    wr(RA_CTRL, 32'h0);
    repeat (30) @(negedge clk);
    exp_word[3] = word_of(phy_lnk[3], phy_ctl[3]); exp_flags[3] = 1'b1;
    rd(RA_FLAGS, d);
    chk(d[3] == 1'b1, "R9 change beats clear", d, 32'h8);
    rd(RA_PORT_BASE + 4'd3, d);
    chk(d[3:0] == exp_word[3], "R9 word stored", d, {28'b0, exp_word[3]});

    // R10 full mask
    wr(RA_MASK, 32'h7F); exp_mask = 7'h7F;
    chk(!irq, "R10 full mask", irq, 0);
    rd(RA_FLAGS, d);
    chk(d == {25'b0, exp_flags}, "R10 mask keeps flags", d, {25'b0, exp_flags});

    // R11 disable between the two reads of a port
    for (int p = 0; p < NP; p++) begin phy_lnk[p] = ~exp_word[p][0]; phy_ctl[p] = 16'(p); end
    log_n = 0;
    wr(RA_CTRL, {1'b1, 1'b0, 6'd0, 11'b0, 5'd6, 3'b0, 5'd0});
    repeat (17) @(negedge clk);
    t = 0;
    do begin @(negedge clk); #2; t++; end while ((log_n % 2) == 0 && t < 200);
    wr(RA_CTRL, 32'h0);
    repeat (30) @(negedge clk);
    t = log_n;
    chk((t % 2) == 0 && t > 0 && log_reg[t - 1] == 0, "R11 pair finished", t, 0);
    repeat (40) @(negedge clk);
    chk(log_n == t && !mdio_req_valid, "R11 idle after disable", log_n, t);
    for (int p = 0; p < t / 2 && p < NP; p++) begin
      logic [3:0] w;
      w = word_of(phy_lnk[p], phy_ctl[p]);
      if (w[0] != exp_word[p][0]) exp_flags[p] = 1'b1;
      exp_word[p] = w;
    end
    check_state();

    // random windows
    for (int k = 0; k < 10; k++) begin
      int f, l;
      f = $urandom % NP;
      l = f + ($urandom % 12);
      run_window(f, l, 220);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule